// File: doc/BRIEF.md
# Gigabit Ethernet Receive Code-Group Synchronizer

This block sits after the 8b/10b decoder in a Gigabit Ethernet receive PCS. Each clock in which `cg_valid` is high it takes one decoded code group. A code group is a byte, a control flag and a decoder validity flag. From this stream the block decides whether code-group synchronization has been acquired, and drives `sync_ok` while it holds.

The block keeps track of whether the next code group falls on an even or an odd position. A comma is accepted only on an even position. A synchronization ordered set is one comma followed by an odd number of valid data groups. Three such sets in a row are needed before `sync_ok` rises. A comma that arrives on an odd position counts as an error.

Once the link is synchronized, errors build up in a counter. Runs of good code groups pay that counter back down, and too many pending errors drop the link back to loss of sync.

Top module: `gbe_rx_sync`

## Requirements
- R1: A comma is a code group with `cg_ctrl`=1, `cg_good`=1 and `cg_byte`=8'hBC. A data group has `cg_ctrl`=0 and `cg_good`=1. A control group with `cg_good`=0, or with any other byte, never starts acquisition.
- R2: After reset, the sequence comma, data, comma, data, comma, data raises `sync_ok` in the cycle after the sixth group is accepted, and not before.
- R3: An ordered set whose comma is followed by three data groups counts toward the three sets needed for sync.
- R4: An accepted comma makes the next position odd. Every other accepted group toggles the position. A comma on an odd position is an error.
- R5: While acquiring, any error (an invalid group or a misplaced comma) returns the block to loss of sync. In the state right after a comma, anything other than a data group also returns it to loss of sync.
- R6: A misplaced comma does not start a new ordered set. Three further complete ordered sets are needed after it.
- R7: While synchronized, each error adds one to a pending-error count. Four consecutive good groups after an error remove one pending error.
- R8: Reaching four pending errors clears `sync_ok` in the following cycle.
- R9: A clock with `cg_valid`=0 changes neither the state nor the position, whatever the other inputs carry.
- R10: Reset forces loss of sync with `sync_ok`=0 and clears all counters, so six fresh groups are needed afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_valid | input | 1 | A code group is present this cycle |
| cg_ctrl | input | 1 | Code group is a control group |
| cg_good | input | 1 | Decoder found the code group valid |
| cg_byte | input | 8 | Decoded byte |
| sync_ok | output | 1 | Code-group synchronization acquired |

## Verification
The fastest acquisition (alternating comma and data) fixes the exact cycle in which sync first rises.

Comma-data-data followed by a comma shows that a misplaced comma is rejected. The six groups after it then separate a design that lets that comma start a set from one that does not. An ordered set with three data groups, with idle cycles carrying comma contents inside it, tests odd-count sets and the hold on idle cycles together.

While synchronized, runs of errors with and without four good groups between them separate correct error cancellation from plain error counting. An invalid group inside acquisition, and a control group with a wrong byte or a bad flag, each give an expected result that a faulty design would reach earlier.

// File: rtl/gbe_sync_pkg.sv
package gbe_sync_pkg;

  typedef enum logic [1:0] {
    ST_LOSS = 2'd0,
    ST_CDET = 2'd1,
    ST_ACQ  = 2'd2,
    ST_SYNC = 2'd3
  } sync_st_e;

  // A comma: control group, decoder-valid, carrying the comma byte.
  function automatic logic f_is_comma(input logic ctrl, input logic good,
                                      input logic [7:0] data, input logic [7:0] comma);
    return ctrl && good && (data == comma);
  endfunction

  // Position after one accepted group: an accepted comma forces odd, others toggle.
  function automatic logic f_next_even(input logic cur_even, input logic force_odd);
    return force_odd ? 1'b0 : !cur_even;
  endfunction

endpackage

// File: rtl/cg_classify.sv
module cg_classify
  import gbe_sync_pkg::*;
#(
  parameter logic [7:0] COMMA_BYTE = 8'hBC
) (
  input  logic       ctrl,
  input  logic       good,
  input  logic [7:0] data,
  input  logic       nxt_even,
  output logic       is_comma,
  output logic       is_data,
  output logic       comma_ok,
  output logic       grp_bad
);

  always_comb begin
    is_comma = f_is_comma(ctrl, good, data, COMMA_BYTE);
    is_data  = !ctrl && good;
    comma_ok = is_comma && nxt_even;
    grp_bad  = !good || (is_comma && !nxt_even);
  end

endmodule

// File: rtl/cg_phase.sv
module cg_phase
  import gbe_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic force_odd,
  output logic nxt_even
);

  always_ff @(posedge clk) begin
    if (!rst_n)   nxt_even <= 1'b1;
    else if (adv) nxt_even <= f_next_even(nxt_even, force_odd);
  end

  AST_PHASE_FORCED_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    adv && force_odd |=> !nxt_even); // R4
  AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !force_odd |=> nxt_even != $past(nxt_even)); // R4
  AST_PHASE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(nxt_even)); // R9

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
  import gbe_sync_pkg::*;
#(
  parameter int SETS_NEEDED = 3,
  parameter int ERR_LIMIT   = 4,
  parameter int GOOD_RUN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_comma,
  input  logic is_data,
  input  logic comma_ok,
  input  logic grp_bad,
  output logic in_loss,
  output logic sync_ok
);

  localparam int SET_W  = $clog2(SETS_NEEDED + 1);
  localparam int ERR_W  = $clog2(ERR_LIMIT);
  localparam int GOOD_W = $clog2(GOOD_RUN);
  localparam logic [SET_W-1:0]  SET_LAST = SET_W'(SETS_NEEDED);
  localparam logic [ERR_W-1:0]  ERR_LAST = ERR_W'(ERR_LIMIT - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_RUN - 1);

  sync_st_e          st_q, st_d;
  logic [SET_W-1:0]  set_q, set_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic [GOOD_W-1:0] good_q, good_d;

  always_comb begin
    st_d   = st_q;
    set_d  = set_q;
    err_d  = err_q;
    good_d = good_q;
    if (valid) begin
      unique case (st_q)
        ST_LOSS: begin
          if (is_comma) begin
            st_d  = ST_CDET;
            set_d = SET_W'(1);
          end
        end
        ST_CDET: begin
          if (is_data) begin
            if (set_q == SET_LAST) begin
              st_d   = ST_SYNC;
              err_d  = '0;
              good_d = '0;
            end else begin
              st_d = ST_ACQ;
            end
          end else begin
            st_d  = ST_LOSS;
            set_d = '0;
          end
        end
        ST_ACQ: begin
          if (grp_bad) begin
            st_d  = ST_LOSS;
            set_d = '0;
          end else if (comma_ok) begin
            st_d  = ST_CDET;
            set_d = set_q + SET_W'(1);
          end
        end
        ST_SYNC: begin
          if (grp_bad) begin
            good_d = '0;
            if (err_q == ERR_LAST) begin
              st_d  = ST_LOSS;
              err_d = '0;
              set_d = '0;
            end else begin
              err_d = err_q + ERR_W'(1);
            end
          end else if (err_q != '0) begin
            if (good_q == GOOD_LAST) begin
              err_d  = err_q - ERR_W'(1);
              good_d = '0;
            end else begin
              good_d = good_q + GOOD_W'(1);
            end
          end
        end
        default: st_d = ST_LOSS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_LOSS;
      set_q  <= '0;
      err_q  <= '0;
      good_q <= '0;
    end else begin
      st_q   <= st_d;
      set_q  <= set_d;
      err_q  <= err_d;
      good_q <= good_d;
    end
  end

  assign in_loss = (st_q == ST_LOSS);
  assign sync_ok = (st_q == ST_SYNC);

  AST_SYNC_AFTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(st_q == ST_CDET && set_q == SET_LAST && valid && is_data)); // R2
  AST_ACQ_BAD_TO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACQ || st_q == ST_CDET) && valid && grp_bad |=> in_loss); // R5
  AST_ERR_LIMIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ok && valid && grp_bad && err_q == ERR_LAST |=> !sync_ok); // R8
  AST_ERR_CLEAR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |-> err_q == '0); // R10
  AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(st_q)); // R9

endmodule

// File: rtl/gbe_rx_sync.sv
module gbe_rx_sync
  import gbe_sync_pkg::*;
#(
  parameter logic [7:0] COMMA_BYTE  = 8'hBC,
  parameter int         SETS_NEEDED = 3,
  parameter int         ERR_LIMIT   = 4,
  parameter int         GOOD_RUN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cg_valid,
  input  logic       cg_ctrl,
  input  logic       cg_good,
  input  logic [7:0] cg_byte,
  output logic       sync_ok
);

  logic nxt_even;
  logic is_comma, is_data, comma_ok, grp_bad;
  logic in_loss, force_odd;

  cg_classify #(.COMMA_BYTE(COMMA_BYTE)) u_cls (
    .ctrl(cg_ctrl), .good(cg_good), .data(cg_byte), .nxt_even(nxt_even),
    .is_comma(is_comma), .is_data(is_data), .comma_ok(comma_ok), .grp_bad(grp_bad)
  );

  // An accepted comma (any comma while out of sync, else only on even) sets odd.
  assign force_odd = comma_ok || (in_loss && is_comma);

  cg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .adv(cg_valid), .force_odd(force_odd), .nxt_even(nxt_even)
  );

  sync_fsm #(.SETS_NEEDED(SETS_NEEDED), .ERR_LIMIT(ERR_LIMIT), .GOOD_RUN(GOOD_RUN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .valid(cg_valid), .is_comma(is_comma), .is_data(is_data),
    .comma_ok(comma_ok), .grp_bad(grp_bad), .in_loss(in_loss), .sync_ok(sync_ok)
  );

  AST_MISPLACED_COMMA_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    cg_valid && !in_loss && is_comma && !nxt_even |-> grp_bad); // R4
  AST_BAD_DECODE_NOT_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_good |-> !is_comma && !is_data); // R1

endmodule

// File: tb/sim_gbe_rx_sync.sv
module sim_gbe_rx_sync;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cg_valid = 1'b0;
  logic       cg_ctrl = 1'b0;
  logic       cg_good = 1'b0;
  logic [7:0] cg_byte = 8'h00;
  logic       sync_ok;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gbe_rx_sync u0 (
    .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .cg_ctrl(cg_ctrl),
    .cg_good(cg_good), .cg_byte(cg_byte), .sync_ok(sync_ok)
  );

  // {valid, ctrl, good, byte}
  localparam logic [10:0] GK = {3'b111, 8'hBC}; // comma
  localparam logic [10:0] GD = {3'b101, 8'h4A}; // data
  localparam logic [10:0] GX = {3'b100, 8'h00}; // invalid group
  localparam logic [10:0] GI = {3'b011, 8'hBC}; // idle cycle with comma contents
  localparam logic [10:0] GN = {3'b110, 8'hBC}; // control, decoder-invalid
  localparam logic [10:0] GC = {3'b111, 8'h3C}; // control, other byte

  // {group, expected sync_ok after it}
  localparam logic [11:0] TBL [64] = '{
    {GK,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b1},
    {GK,1'b1},{GD,1'b1},{GX,1'b1},{GD,1'b1},{GD,1'b1},{GD,1'b1},{GD,1'b1},
    {GX,1'b1},{GX,1'b1},{GX,1'b1},{GX,1'b0},
    {GK,1'b0},{GD,1'b0},{GD,1'b0},{GK,1'b0},
    {GD,1'b0},{GK,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b1},
    {GX,1'b1},{GX,1'b1},{GX,1'b1},{GX,1'b0},
    {GK,1'b0},{GD,1'b0},{GI,1'b0},{GD,1'b0},{GI,1'b0},{GD,1'b0},
    {GK,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b1},
    {GX,1'b1},{GX,1'b1},{GX,1'b1},{GX,1'b0},
    {GK,1'b0},{GD,1'b0},{GX,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b0},
    {GK,1'b0},{GD,1'b0},{GK,1'b0},{GD,1'b1},
    {GX,1'b1},{GX,1'b1},{GX,1'b1},{GX,1'b0},
    {GK,1'b0},{GX,1'b0},{GK,1'b0},{GD,1'b0}
  };

  function automatic string tag_of(input int i);
    if (i <= 5)  return "R2 fastest acquisition";
    if (i <= 12) return "R7 error then four good";
    if (i <= 16) return "R8 four errors drop";
    if (i <= 20) return "R4 comma on odd position";
    if (i <= 27) return "R6 misplaced comma not counted";
    if (i <= 31) return "R8 four errors drop";
    if (i <= 41) return "R3 odd data count, R9 idle hold";
    if (i <= 45) return "R8 four errors drop";
    if (i <= 55) return "R5 invalid group while acquiring";
    if (i <= 59) return "R8 four errors drop";
    return "R5 invalid group after comma";
  endfunction

  task automatic drive(input logic [10:0] g);
    @(negedge clk);
    {cg_valid, cg_ctrl, cg_good, cg_byte} = g;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (sync_ok !== exp) begin
      errors++;
      $display("FAIL %s: sync_ok=%0b expected %0b", tag, sync_ok, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(1'b0, "R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(1'b0, "R10 after reset release");

    for (int i = 0; i < 64; i++) begin
      drive(TBL[i][11:1]);
      check(TBL[i][0], tag_of(i));
    end

    // complete acquisition from the first set left by the table
    drive(GK); drive(GD); drive(GK); drive(GD);
    check(1'b1, "R2 sync reached");

    // idle cycles with decoder errors flagged must not disturb sync
    for (int i = 0; i < 5; i++) drive({3'b010, 8'h00});
    check(1'b1, "R9 idle errors ignored");

    // reset in sync
    @(negedge clk);
    rst_n = 1'b0;
    cg_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    #2;
    check(1'b0, "R10 reset drops sync");
    @(negedge clk);
    rst_n = 1'b1;

    // non-comma control groups must not start acquisition
    drive(GN); drive(GC); drive(GK); drive(GD); drive(GK); drive(GD);
    check(1'b0, "R1 non-comma control groups");
    drive(GK); drive(GD);
    check(1'b1, "R1 sync after real commas");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule